// File: doc/BRIEF.md
# Thread-Tagged Branch Target Buffer

This block is a direct-mapped table that remembers where taken branches went. The front end presents a program counter and a hardware thread number on the lookup port. In the same cycle the block answers with a hit flag and the branch target stored for that slot. When a branch resolves, the back end writes its address, its target and its thread number through the update port. The write replaces whatever the mapped slot held.

Each slot keeps a valid flag, an address tag, a target address and the number of the thread that owns it. The slot number comes from the program counter once the instruction-alignment bits below it are discarded. The tag is the next field up, so tag and slot number share no bits. A hit needs three things: a valid slot, an equal tag and an equal thread number. Two threads that run the same code therefore never take each other's predictions.

The table is emptied in two ways: by the asynchronous reset, or by a synchronous flush for one cycle.

Top module: `thread_btb`

## Requirements
- R1: After reset every slot is invalid, with its tag, target and thread fields at zero. Every lookup misses, and `lk_target_o` reads 0.
- R2: The slot number is `pc[SHIFT +: log2(ENTRIES)]`. PC bits below `SHIFT` have no effect on a lookup or an update.
- R3: The tag is the `TAG_W` bits of the PC that start directly above the slot-number field. PC bits above the tag have no effect.
- R4: A lookup hits only when the addressed slot is valid and its stored tag equals the lookup tag. The same slot with a different tag misses.
- R5: A lookup hits only when the stored thread number equals `lk_tid_i`. An equal tag owned by another thread misses.
- R6: An update (`up_en_i` = 1) overwrites all fields of the addressed slot, whatever it held, and sets the slot valid from the next clock edge on.
- R7: A lookup in the same cycle as an update to the same slot sees the slot's contents from before the update.
- R8: `flush_i` = 1 invalidates every slot and zeroes its fields at the next clock edge. It overrides an update in the same cycle.
- R9: `lk_target_o` always shows the target field of the addressed slot. On a hit this is the target of the most recent update to that slot.
- R10: `ENTRIES` must be a power of two of at least 2. `SHIFT` + log2(`ENTRIES`) + `TAG_W` must not exceed `ADDR_W`. Either violation stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous invalidate of all slots |
| lk_pc_i | input | ADDR_W | Lookup program counter |
| lk_tid_i | input | TID_W | Lookup thread number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_target_o | output | ADDR_W | Target field of the addressed slot |
| up_en_i | input | 1 | Update strobe |
| up_pc_i | input | ADDR_W | Branch address to record |
| up_target_i | input | ADDR_W | Branch target to record |
| up_tid_i | input | TID_W | Owning thread number |

## Verification
An update and a lookup can address the same slot in one cycle. A flush and an update can also coincide. The bench provokes both repeatedly: deliberately while filling and rewriting slots, and by chance during a long pseudo-random run over a small set of tags and threads. A reference table kept in the bench is sampled just after each negative edge, before that cycle's write is applied to it. This means a same-cycle lookup must match the old slot contents. Flush is applied to the reference table ahead of any write, so a flush that collides with an update must leave the slot empty.

// File: rtl/thread_btb_pkg.sv
package thread_btb_pkg;
  function automatic bit is_pow2(int unsigned n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/thread_btb_split.sv
module thread_btb_split #(
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 2,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int TAG_LO = SHIFT + IDX_W;

  logic unused_pc;
  assign unused_pc = ^pc_i;

  assign idx_o = pc_i[SHIFT +: IDX_W];
  assign tag_o = pc_i[TAG_LO +: TAG_W];
endmodule

// File: rtl/thread_btb_store.sv
module thread_btb_store #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  parameter int TID_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [ADDR_W-1:0] wtgt_i,
  input  logic [TID_W-1:0]  wtid_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic              rvalid_o,
  output logic [TAG_W-1:0]  rtag_o,
  output logic [ADDR_W-1:0] rtgt_o,
  output logic [TID_W-1:0]  rtid_o
);
  logic              vld_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0] tgt_q [ENTRIES];
  logic [TID_W-1:0]  tid_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
        tid_q[e] <= '0;
      end else if (flush_i) begin
        // flush dominates a colliding write
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
        tid_q[e] <= '0;
      end else if (sel) begin
        vld_q[e] <= 1'b1;
        tag_q[e] <= wtag_i;
        tgt_q[e] <= wtgt_i;
        tid_q[e] <= wtid_i;
      end
    end
  end

  assign rvalid_o = vld_q[ridx_i];
  assign rtag_o   = tag_q[ridx_i];
  assign rtgt_o   = tgt_q[ridx_i];
  assign rtid_o   = tid_q[ridx_i];
endmodule

// File: rtl/thread_btb_match.sv
module thread_btb_match #(
  parameter int TAG_W = 8,
  parameter int TID_W = 2
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] stag_i,
  input  logic [TAG_W-1:0] ltag_i,
  input  logic [TID_W-1:0] stid_i,
  input  logic [TID_W-1:0] ltid_i,
  output logic             hit_o
);
  assign hit_o = valid_i && (stag_i == ltag_i) && (stid_i == ltid_i);
endmodule

// File: rtl/thread_btb.sv
module thread_btb #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  parameter int SHIFT   = 2,
  parameter int TID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  input  logic [TID_W-1:0]  lk_tid_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              up_en_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic [ADDR_W-1:0] up_target_i,
  input  logic [TID_W-1:0]  up_tid_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  // R10 elaboration guards
  if (!thread_btb_pkg::is_pow2(ENTRIES)) begin : g_bad_entries
    $error("thread_btb: ENTRIES must be a power of two >= 2");
  end
  if (SHIFT + IDX_W + TAG_W > ADDR_W) begin : g_bad_fit
    $error("thread_btb: SHIFT + index + tag exceed ADDR_W");
  end

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag, s_tag;
  logic [TID_W-1:0]  s_tid;
  logic              s_vld;

  thread_btb_split #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_split_lk (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );

  thread_btb_split #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_split_up (
    .pc_i(up_pc_i), .idx_o(up_idx), .tag_o(up_tag)
  );

  thread_btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .we_i     (up_en_i),
    .widx_i   (up_idx),
    .wtag_i   (up_tag),
    .wtgt_i   (up_target_i),
    .wtid_i   (up_tid_i),
    .ridx_i   (lk_idx),
    .rvalid_o (s_vld),
    .rtag_o   (s_tag),
    .rtgt_o   (lk_target_o),
    .rtid_o   (s_tid)
  );

  thread_btb_match #(.TAG_W(TAG_W), .TID_W(TID_W)) i_match (
    .valid_i (s_vld),
    .stag_i  (s_tag),
    .ltag_i  (lk_tag),
    .stid_i  (s_tid),
    .ltid_i  (lk_tid_i),
    .hit_o   (lk_hit_o)
  );
endmodule

// File: rtl/thread_btb_chk.sv
module thread_btb_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  parameter int SHIFT   = 2,
  parameter int TID_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic [ADDR_W-1:0] lk_pc_i,
  input logic [TID_W-1:0]  lk_tid_i,
  input logic              lk_hit_o,
  input logic [ADDR_W-1:0] lk_target_o,
  input logic              up_en_i,
  input logic [ADDR_W-1:0] up_pc_i,
  input logic [ADDR_W-1:0] up_target_i,
  input logic [TID_W-1:0]  up_tid_i
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_LO = SHIFT + IDX_W;

  logic wr;
  assign wr = up_en_i && !flush_i;

  // R8: a flush leaves nothing to hit on the following cycle
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  // R6, R9: a write is visible to an identical lookup one cycle later
  a_r6_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr) && lk_pc_i == $past(up_pc_i) && lk_tid_i == $past(up_tid_i))
    |-> (lk_hit_o && lk_target_o == $past(up_target_i)));

  // R5: same address, other thread, just written -> miss
  a_r5_tid_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr) && lk_pc_i == $past(up_pc_i) && lk_tid_i != $past(up_tid_i))
    |-> !lk_hit_o);

  // R4: same slot, other tag, just written -> miss
  a_r4_tag_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr) && lk_pc_i[SHIFT +: IDX_W] == $past(up_pc_i[SHIFT +: IDX_W])
      && lk_pc_i[TAG_LO +: TAG_W] != $past(up_pc_i[TAG_LO +: TAG_W]))
    |-> !lk_hit_o);

  // R1: hit output is always a defined level outside reset
  a_r1_hit_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(lk_hit_o));
endmodule

bind thread_btb thread_btb_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SHIFT(SHIFT), .TID_W(TID_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .lk_pc_i(lk_pc_i), .lk_tid_i(lk_tid_i), .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
  .up_en_i(up_en_i), .up_pc_i(up_pc_i), .up_target_i(up_target_i), .up_tid_i(up_tid_i)
);

// File: tb/test_thread_btb.sv
module test_thread_btb;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 32;
  localparam int TAG_W   = 8;
  localparam int SHIFT   = 2;
  localparam int TID_W   = 2;
  localparam int IDX_W   = 4;
  localparam int TAG_LO  = SHIFT + IDX_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic [ADDR_W-1:0] lk_pc_i = '0;
  logic [TID_W-1:0]  lk_tid_i = '0;
  logic              lk_hit_o;
  logic [ADDR_W-1:0] lk_target_o;
  logic              up_en_i = 1'b0;
  logic [ADDR_W-1:0] up_pc_i = '0;
  logic [ADDR_W-1:0] up_target_i = '0;
  logic [TID_W-1:0]  up_tid_i = '0;

  always #5 clk_i = ~clk_i;

  thread_btb #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SHIFT(SHIFT), .TID_W(TID_W)) i_thread_btb (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .lk_pc_i(lk_pc_i), .lk_tid_i(lk_tid_i), .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
    .up_en_i(up_en_i), .up_pc_i(up_pc_i), .up_target_i(up_target_i), .up_tid_i(up_tid_i)
  );

  // reference table
  bit                m_vld [ENTRIES];
  logic [TAG_W-1:0]  m_tag [ENTRIES];
  logic [ADDR_W-1:0] m_tgt [ENTRIES];
  logic [TID_W-1:0]  m_tid [ENTRIES];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic int idx_of(logic [ADDR_W-1:0] pc);
    return int'((pc >> SHIFT) % ENTRIES);
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] pc);
    return TAG_W'((pc >> TAG_LO) & ((1 << TAG_W) - 1));
  endfunction
  function automatic logic [ADDR_W-1:0] mk_pc(logic [31:0] hi, int tag, int idx, int lo);
    return (hi & 32'hFFFF_C000) | ADDR_W'(tag << TAG_LO) | ADDR_W'(idx << SHIFT) | ADDR_W'(lo & 3);
  endfunction

  task automatic model_clear();
    for (int e = 0; e < ENTRIES; e++) begin
      m_vld[e] = 1'b0; m_tag[e] = '0; m_tgt[e] = '0; m_tid[e] = '0;
    end
  endtask

  task automatic check(string req, logic exp_hit, logic [ADDR_W-1:0] exp_tgt);
    checks++;
    if (lk_hit_o !== exp_hit || lk_target_o !== exp_tgt) begin
      errors++;
      $display("FAIL %s pc=%h tid=%0d hit=%b tgt=%h expected hit=%b tgt=%h",
               req, lk_pc_i, lk_tid_i, lk_hit_o, lk_target_o, exp_hit, exp_tgt);
    end
  endtask

  // one cycle: drive at negedge, sample lookup (pre-write state), then commit to model
  task automatic step(string req, bit fl, bit we, logic [ADDR_W-1:0] upc,
                      logic [ADDR_W-1:0] utgt, logic [TID_W-1:0] utid,
                      logic [ADDR_W-1:0] lpc, logic [TID_W-1:0] ltid);
    int li;
    logic eh;
    @(negedge clk_i);
    flush_i = fl; up_en_i = we; up_pc_i = upc; up_target_i = utgt; up_tid_i = utid;
    lk_pc_i = lpc; lk_tid_i = ltid;
    #1;
    li = idx_of(lpc);
    eh = m_vld[li] && m_tag[li] == tag_of(lpc) && m_tid[li] == ltid;
    check(req, eh, m_tgt[li]);
    if (fl) model_clear();
    else if (we) begin
      m_vld[idx_of(upc)] = 1'b1;
      m_tag[idx_of(upc)] = tag_of(upc);
      m_tgt[idx_of(upc)] = utgt;
      m_tid[idx_of(upc)] = utid;
    end
  endtask

  task automatic look(string req, logic [ADDR_W-1:0] lpc, logic [TID_W-1:0] ltid);
    step(req, 1'b0, 1'b0, '0, '0, '0, lpc, ltid);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty after reset
    for (int i = 0; i < ENTRIES; i++) look("R1", mk_pc(32'h0, 0, i, 0), TID_W'(i));

    // R6: fill every slot, thread = slot mod 4
    for (int i = 0; i < ENTRIES; i++)
      step("R6", 0, 1, mk_pc(32'hA000_0000, 8'h30 + i, i, 0), 32'hB000_0000 + i * 16,
           TID_W'(i % 4), mk_pc(0, 0, 0, 0), 0);

    for (int i = 0; i < ENTRIES; i++) begin
      look("R9", mk_pc(32'hA000_0000, 8'h30 + i, i, 0), TID_W'(i % 4));
      look("R2", mk_pc(32'hA000_0000, 8'h30 + i, i, i + 1), TID_W'(i % 4));
      look("R3", mk_pc(32'h5FFF_C000, 8'h30 + i, i, 0), TID_W'(i % 4));
      look("R5", mk_pc(32'hA000_0000, 8'h30 + i, i, 0), TID_W'((i + 1) % 4));
      look("R4", mk_pc(32'hA000_0000, 8'h31 + i, i, 0), TID_W'(i % 4));
    end

    // R7: same-cycle lookup sees old target, next cycle sees new
    for (int i = 0; i < ENTRIES; i++) begin
      step("R7", 0, 1, mk_pc(32'hA000_0000, 8'h30 + i, i, 0), 32'hC000_0000 + i,
           TID_W'(i % 4), mk_pc(32'hA000_0000, 8'h30 + i, i, 0), TID_W'(i % 4));
      look("R6", mk_pc(32'hA000_0000, 8'h30 + i, i, 0), TID_W'(i % 4));
    end

    // R6: overwrite by another thread and tag
    step("R6", 0, 1, mk_pc(0, 8'h77, 3, 0), 32'hDEAD_0000, 2, mk_pc(0, 0, 0, 0), 0);
    look("R6", mk_pc(0, 8'h77, 3, 0), 2);
    look("R4", mk_pc(32'hA000_0000, 8'h33, 3, 0), 3);

    // R8: flush colliding with update
    step("R8", 1, 1, mk_pc(0, 8'h55, 5, 0), 32'h1111_0000, 1, mk_pc(32'hA000_0000, 8'h35, 5, 0), 1);
    for (int i = 0; i < ENTRIES; i++) look("R8", mk_pc(32'hA000_0000, 8'h30 + i, i, 0), TID_W'(i % 4));
    look("R8", mk_pc(0, 8'h55, 5, 0), 1);

    // mixed pseudo-random run
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      lfsr = nxt(lfsr); a = lfsr;
      lfsr = nxt(lfsr); b = lfsr;
      step("R4", (a[31:26] == 0), a[0],
           mk_pc(b, int'(a[1]) * 8'h5A + 1, int'(a[5:2]), int'(a[7:6])), b ^ a, a[9:8],
           mk_pc(a, int'(b[1]) * 8'h5A + 1, int'(b[5:2]), int'(b[7:6])), b[9:8]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule